// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be kept by looking only at its 48-bit destination address. The address arrives one byte per clock, the first byte marked by a start flag. While the bytes stream in, the block runs a reflected CRC-32 over them. When the sixth byte has been taken, it forms a registered keep/drop decision.

For a group (multicast) destination, six bits of the CRC select one bit of a 64-bit hash table. The table is held as four 16-bit words that the host writes through a simple load port. Setting the table to all ones passes every group address, and clearing it passes none. For an individual (unicast) destination, the block compares the address against a programmed station address. A promiscuous control passes every frame.

Top module: `mhf_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are low and all four table words are zero, so a group address is rejected until the table is loaded.
- R2: The CRC is the reflected CRC-32. It uses polynomial 0xEDB88320 and starts from all ones. There is no final inversion. The address bytes are taken first to last, and each byte is taken from bit 0 upward. The hash index is CRC bits 31:26.
- R3: Hash bits 5:4 pick the table word and hash bits 3:0 pick the bit inside that word, so the selected bit is table bit 16*word+bit. A group address is accepted exactly when that bit is 1.
- R4: An address is a group address when bit 0 of its first byte (the byte sent with `byte_sof`) is 1. Only group addresses use the hash table.
- R5: With all 64 table bits set, every group address is accepted.
- R6: With the table clear and promiscuous mode off, every group address is rejected.
- R7: An individual address is accepted only when it equals `station_addr`, where address byte i is `station_addr[8*i+7:8*i]`. The table contents have no effect on individual addresses.
- R8: When `promisc_en` is high, every address is accepted, whatever the table holds.
- R9: `dec_valid` is a one-cycle pulse. It appears 6 rising edges after the edge that samples the first byte. `dec_accept` is low whenever `dec_valid` is low.
- R10: A byte with `byte_sof` always restarts capture, dropping any partial address. A byte without `byte_sof` while no address is in progress is ignored.
- R11: When `tbl_we` is high, `tbl_wdata` is written to table word `tbl_sel` (0 to 3). The new value applies to every decision formed after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Table word write strobe |
| tbl_sel | input | 2 | Table word index for a write |
| tbl_wdata | input | 16 | Table word write data |
| station_addr | input | 48 | Own individual address, byte 0 in bits 7:0 |
| promisc_en | input | 1 | Accept every address |
| byte_vld | input | 1 | Address byte present |
| byte_sof | input | 1 | Marks the first address byte |
| byte_data | input | 8 | Address byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Keep the frame (qualified by dec_valid) |

## Verification
The bench tries the filter with several patterns, and each pattern tells a different kind of error apart.

- Full-table, clear-table and promiscuous patterns separate the three ways a frame can pass, without relying on the CRC.
- Exact-station and one-bit-off individual addresses, with the table full, show that the table never leaks into the individual-address path.
- Group addresses are checked against tables holding only the one hashed bit, and against tables holding every bit except that one. This catches a wrong CRC order or preset, and a word/bit split that is swapped or shifted.
- A truncated address followed by a fresh start, and stray bytes without a start flag, show that capture restarts cleanly and that loose bytes are never mixed in.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

  // One byte through the reflected CRC-32, bit 0 of the byte first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  b_in);
    logic [31:0] r;
    r = c_in;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b_in[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else                r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_vld,
  input  logic                      byte_sof,
  input  logic [7:0]                byte_data,
  output logic [31:0]               crc_q,
  output logic [8*ADDR_BYTES-1:0]   addr_q,
  output logic                      done_q
);
  import mhf_pkg::*;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [31:0]             crc_n;
  logic [8*ADDR_BYTES-1:0] addr_n;
  logic                    in_prog, ld_en, done_n;

  assign in_prog = (cnt_q != '0) && (cnt_q < CNT_W'(ADDR_BYTES));
  assign ld_en   = byte_vld && (byte_sof || in_prog);

  always_comb begin
    crc_n  = crc_q;
    addr_n = addr_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (byte_vld && byte_sof) begin
      crc_n       = crc_step_byte(CRC_PRESET, byte_data);
      addr_n      = '0;
      addr_n[7:0] = byte_data;
      cnt_n       = CNT_W'(1);
    end else if (byte_vld && in_prog) begin
      crc_n = crc_step_byte(crc_q, byte_data);
      for (int i = 1; i < ADDR_BYTES; i++) begin
        if (cnt_q == CNT_W'(i)) addr_n[8*i +: 8] = byte_data;
      end
      cnt_n  = cnt_q + CNT_W'(1);
      done_n = (cnt_q == CNT_W'(ADDR_BYTES - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= CRC_PRESET;
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ld_en) begin
        crc_q  <= crc_n;
        addr_q <= addr_n;
        cnt_q  <= cnt_n;
      end
      done_q <= done_n;
    end
  end
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(NUM_WORDS)-1:0]   wr_sel,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [NUM_WORDS*WORD_W-1:0]    tbl_flat
);
  localparam int SEL_W = $clog2(NUM_WORDS);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              word_en;
    assign word_en = wr_en && (wr_sel == SEL_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= wr_data;
    end
    assign tbl_flat[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_WORDS  = 4,
  parameter int WORD_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          done,
  input  logic [31:0]                   crc,
  input  logic [8*ADDR_BYTES-1:0]       addr,
  input  logic [8*ADDR_BYTES-1:0]       station,
  input  logic                          promisc,
  input  logic [NUM_WORDS*WORD_W-1:0]   tbl_flat,
  output logic                          dec_valid_q,
  output logic                          dec_accept_q
);
  localparam int SEL_W  = $clog2(NUM_WORDS);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int HASH_W = SEL_W + BIT_W;

  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [HASH_W-1:0] hash;
  logic [SEL_W-1:0]  word_sel;
  logic [BIT_W-1:0]  bit_sel;
  logic              hit, is_group, accept_n;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_unpack
    assign words[w] = tbl_flat[w*WORD_W +: WORD_W];
  end

  assign hash     = crc[31 -: HASH_W];
  assign word_sel = hash[HASH_W-1 -: SEL_W];
  assign bit_sel  = hash[BIT_W-1:0];
  assign hit      = words[word_sel][bit_sel];
  assign is_group = addr[0];

  always_comb begin
    if (promisc)       accept_n = 1'b1;
    else if (is_group) accept_n = hit;
    else               accept_n = (addr == station);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q  <= 1'b0;
      dec_accept_q <= 1'b0;
    end else begin
      dec_valid_q  <= done;
      dec_accept_q <= done && accept_n;
    end
  end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_WORDS  = 4,
  parameter int WORD_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tbl_we,
  input  logic [$clog2(NUM_WORDS)-1:0]  tbl_sel,
  input  logic [WORD_W-1:0]             tbl_wdata,
  input  logic [8*ADDR_BYTES-1:0]       station_addr,
  input  logic                          promisc_en,
  input  logic                          byte_vld,
  input  logic                          byte_sof,
  input  logic [7:0]                    byte_data,
  output logic                          dec_valid,
  output logic                          dec_accept
);
  localparam int TBL_BITS = NUM_WORDS * WORD_W;

  logic [1:0]              rst_sync_q;
  logic                    rst_n_int;
  logic [31:0]             frm_crc;
  logic [8*ADDR_BYTES-1:0] frm_addr;
  logic                    frm_done;
  logic [TBL_BITS-1:0]     tbl_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  mhf_crc_acc #(.ADDR_BYTES(ADDR_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n_int),
    .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_data(byte_data),
    .crc_q(frm_crc), .addr_q(frm_addr), .done_q(frm_done)
  );

  mhf_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_tbl (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(tbl_we), .wr_sel(tbl_sel), .wr_data(tbl_wdata),
    .tbl_flat(tbl_flat)
  );

  mhf_decide #(.ADDR_BYTES(ADDR_BYTES), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst_n(rst_n_int),
    .done(frm_done), .crc(frm_crc), .addr(frm_addr),
    .station(station_addr), .promisc(promisc_en), .tbl_flat(tbl_flat),
    .dec_valid_q(dec_valid), .dec_accept_q(dec_accept)
  );
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
  parameter int TBL_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                promisc_en,
  input logic                dec_valid,
  input logic                dec_accept,
  input logic                done_int,
  input logic                group_bit,
  input logic [TBL_BITS-1:0] tbl_bits
);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  assert_follows_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_int |=> dec_valid);

  assert_promisc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(promisc_en)) |-> dec_accept);

  assert_full_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(&tbl_bits) && $past(group_bit)) |-> dec_accept);

  assert_clear_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(tbl_bits == '0) && $past(group_bit) && !$past(promisc_en))
      |-> !dec_accept);
endmodule

bind mhf_filter mhf_filter_chk #(.TBL_BITS(NUM_WORDS * WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .done_int(frm_done), .group_bit(frm_addr[0]), .tbl_bits(tbl_flat)
);

// File: tb/sim_mhf_filter.sv
module sim_mhf_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [1:0]  tbl_sel;
  logic [15:0] tbl_wdata;
  logic [47:0] station_addr;
  logic        promisc_en;
  logic        byte_vld, byte_sof;
  logic [7:0]  byte_data;
  logic        dec_valid, dec_accept;

  int n_tests = 0;
  int n_fail  = 0;
  int n_pulse = 0;

  always #4 clk = ~clk;

  mhf_filter u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_wdata(tbl_wdata), .station_addr(station_addr), .promisc_en(promisc_en),
    .byte_vld(byte_vld), .byte_sof(byte_sof), .byte_data(byte_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  always @(posedge clk) if (dec_valid) n_pulse++;

  localparam logic [47:0] STN = 48'h665544332202;

  typedef struct packed {
    logic [47:0] addr;
    logic        prom;
    logic [63:0] tbl;
    logic [1:0]  exp;   // 0 reject, 1 accept, 2 from reference model
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{48'h0100005E0001, 1'b0, 64'hFFFFFFFFFFFFFFFF, 2'd1},
    '{48'h0100005E0001, 1'b0, 64'h0000000000000000, 2'd0},
    '{48'hFFFFFFFFFFFF, 1'b1, 64'h0000000000000000, 2'd1},
    '{STN,              1'b0, 64'h0000000000000000, 2'd1},
    '{48'hE65544332202, 1'b0, 64'hFFFFFFFFFFFFFFFF, 2'd0},
    '{48'h123456789A10, 1'b1, 64'h0000000000000000, 2'd1},
    '{48'h123456789A33, 1'b0, 64'h0123456789ABCDEF, 2'd2},
    '{48'hABCDEF012345, 1'b0, 64'hF0F00F0FAAAA5555, 2'd2},
    '{48'hFFFFFFFFFFFF, 1'b0, 64'h8000000000000001, 2'd2}
  };

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[0] ^ a[k];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input logic p,
                                      input logic [63:0] t);
    logic [5:0] h;
    h = ref_hash(a);
    if (p)         return 1'b1;
    else if (a[0]) return t[{h[5:4], h[3:0]}];
    else           return a == STN;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_tbl(input logic [63:0] t);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_sel = 2'(w); tbl_wdata = t[16*w +: 16];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send_bytes(input logic [47:0] a, input int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_sof = (i == 0); byte_data = a[8*i +: 8];
    end
    @(negedge clk);
    byte_vld = 1'b0; byte_sof = 1'b0;
  endtask

  // Full address then check timing (R9) and result.
  task automatic run_addr(input logic [47:0] a, input logic exp, input string req);
    send_bytes(a, 6);
    chk("R9 no early valid", dec_valid, 1'b0);
    @(negedge clk);
    chk("R9 valid on 6th edge", dec_valid, 1'b1);
    chk(req, dec_accept, exp);
    @(negedge clk);
    chk("R9 single pulse", {dec_valid, dec_accept}, 2'b00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] gaddr [4];
    logic [5:0]  h;
    logic        e;
    int          p0;
    gaddr[0] = 48'h0100005E0001; gaddr[1] = 48'h333300000001;
    gaddr[2] = 48'h0F1E2D3C4B5B; gaddr[3] = 48'hFFFFFFFFFFFF;
    rst_n = 1'b0; tbl_we = 1'b0; tbl_sel = '0; tbl_wdata = '0;
    station_addr = STN; promisc_en = 1'b0;
    byte_vld = 1'b0; byte_sof = 1'b0; byte_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid/accept", {dec_valid, dec_accept}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", {dec_valid, dec_accept}, 2'b00);
    run_addr(48'h0100005E0001, 1'b0, "R1 R4 table clear after reset");

    for (int v = 0; v < NV; v++) begin
      load_tbl(VECS[v].tbl);
      promisc_en = VECS[v].prom;
      e = (VECS[v].exp == 2'd2) ? ref_accept(VECS[v].addr, VECS[v].prom, VECS[v].tbl)
                                : VECS[v].exp[0];
      run_addr(VECS[v].addr, e, "R2 R5 R6 R7 R8 vector");
    end
    promisc_en = 1'b0;

    // R2 R3: single-bit tables around the hashed position
    for (int g = 0; g < 4; g++) begin
      h = ref_hash(gaddr[g]);
      load_tbl(64'd1 << h);
      run_addr(gaddr[g], 1'b1, "R3 only hashed bit set");
      load_tbl(~(64'd1 << h));
      run_addr(gaddr[g], 1'b0, "R3 all but hashed bit");
    end

    // R11: rewrite one word and see it take effect
    h = ref_hash(gaddr[1]);
    load_tbl(64'd0);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = h[5:4]; tbl_wdata = 16'd1 << h[3:0];
    @(negedge clk);
    tbl_we = 1'b0;
    run_addr(gaddr[1], 1'b1, "R11 single word write");

    // R10: partial address then restart with station address
    load_tbl(64'hFFFFFFFFFFFFFFFF);
    p0 = n_pulse;
    send_bytes(48'h0100005E0001, 3);
    repeat (4) @(negedge clk);
    chk("R10 partial gives no decision", n_pulse - p0, 0);
    run_addr(STN, 1'b1, "R10 restart uses new address");
    chk("R10 one decision total", n_pulse - p0, 1);

    // R10: stray bytes without start flag are ignored
    p0 = n_pulse;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_sof = 1'b0; byte_data = 8'hFF;
    end
    @(negedge clk);
    byte_vld = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 stray bytes no decision", n_pulse - p0, 0);
    load_tbl(64'd0);
    run_addr(STN, 1'b1, "R10 R7 stray bytes not mixed in");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule